// File: doc/BRIEF.md
# First-Come First-Served Bus Arbiter

This block shares one bus among four requesters and grants it in the order the requests arrived, not by a fixed ranking of the lines. Each requester pulls its own active-low request line low to ask for the bus. It holds the line low while it uses the bus and releases it (drives it high) when done. The arbiter answers on a matching active-low grant line. Requests that come in while the bus is busy wait in an arrival-order queue, and they are served one after another as each holder lets go.

The request lines may be driven from other clock domains. Each one passes through a two-flop synchronizer. A change of request is then seen on the synchronized edge, and arrivals seen in the same clock cycle count as simultaneous. A pseudo-random pick, driven by a free-running 4-bit shift register, chooses the winner among simultaneous arrivals. The others line up behind the winner by index. When such a tie lands on an idle bus, the grants stay off for one extra clock while the winner is chosen. A common active-low enable gates all grants without touching the queue. A requester can leave the queue before it is served.

Top module: `fcfs_bus_arbiter`

## Requirements
- R1: During and after reset, with no request asserted, all four grant lines are high (inactive) and the queue is empty.
- R2: The arbiter may be idle with enable low. Grant line n then goes low for request line n, and only n. A request driven low between clock edges shows its grant after the third following rising edge, and not after the second.
- R3: Requests are served strictly in arrival order. A request arriving while another holds the grant waits. When the holder releases, the earliest waiting request is granted three rising edges after the release.
- R4: At most one grant line is low at any time. On a hand-over, the old grant rises and the new grant falls after the same clock edge, with no gap and no overlap.
- R5: Two or more requests may arrive in the same cycle while the queue is otherwise empty. Exactly one of them is then granted, one clock later than a lone request would be (after the fourth rising edge). All grants stay high until then.
- R6: Among simultaneous arrivals, the requesters that lose the tie are queued directly behind the winner in ascending line index (0 before 1 before 2 before 3).
- R7: While enable is high, all four grant lines are high, and this responds without waiting for a clock. Arrivals and releases are still recorded. When enable returns low, the grant reflects the queue as if enable had stayed low.
- R8: A waiting request that is withdrawn before being served leaves the queue. The current grant does not change, and the order of the other waiting requesters is kept.
- R9: A request line held permanently high never receives a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 4 | Request lines, active low, bit n is requester n |
| en_n | input | 1 | Common grant enable, active low |
| gnt_n | output | 4 | Grant lines, active low, one-hot or none |

## Verification
A corrupted queue entry or count shows up at the ports as the wrong requester being granted. This is seen no later than three edges after the holder releases the bus, or as a grant that never appears. A dropped or doubled entry breaks the order sweep over every four-requester arrival permutation at the first hand-over it affects. A bad tie-break or tie-hold state shows as a grant one cycle early, as a grant to a requester outside the tied set, or as losers granted out of index order. A grant-path fault with two lines low, or a grant while enable is high, is caught by a check made on every cycle.

// File: rtl/fcfs_pkg.sv
package fcfs_pkg;
  localparam int ARB_N = 4;
  localparam int ID_W  = $clog2(ARB_N);
  localparam int CNT_W = $clog2(ARB_N + 1);

  typedef logic [ID_W-1:0] reqId_t;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic [ARB_N-1:0] dropMask;   // requesters that withdrew this cycle
    logic [ARB_N-1:0] addMask;    // requesters that arrived this cycle
    logic             firstValid; // a tie winner goes in ahead of the rest
    reqId_t           firstId;
  } qStrobe_t;
endpackage

// File: rtl/fcfs_req_sync.sv
module fcfs_req_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] reqRaw_n,
  output logic [WIDTH-1:0] reqActive
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], reqRaw_n[b]};
    end
    assign reqActive[b] = ~chain[LAST];
  end
endmodule

// File: rtl/fcfs_queue_dp.sv
module fcfs_queue_dp
  import fcfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  qStrobe_t         strb,
  output reqId_t           headId,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] liveCnt
);
  reqId_t           slot  [ARB_N];
  reqId_t           slotNx[ARB_N];
  logic [CNT_W-1:0] countNx;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < ARB_N; i++) slotNx[i] = slot[i];
    // drop withdrawn entries, keeping the order of the rest
    for (int i = 0; i < ARB_N; i++) begin
      if (i < int'(count) && !strb.dropMask[slot[i]] && n < ARB_N) begin
        slotNx[n[ID_W-1:0]] = slot[i];
        n++;
      end
    end
    liveCnt = CNT_W'(n);
    // tie winner first
    if (strb.firstValid && n < ARB_N) begin
      slotNx[n[ID_W-1:0]] = strb.firstId;
      n++;
    end
    // remaining arrivals in ascending index
    for (int j = 0; j < ARB_N; j++) begin
      if (strb.addMask[j] && !(strb.firstValid && strb.firstId == ID_W'(j)) && n < ARB_N) begin
        slotNx[n[ID_W-1:0]] = ID_W'(j);
        n++;
      end
    end
    countNx = CNT_W'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < ARB_N; i++) slot[i] <= '0;
    end else begin
      count <= countNx;
      for (int i = 0; i < ARB_N; i++) slot[i] <= slotNx[i];
    end
  end

  assign headId = slot[0];

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ARB_N)) else $error("queue count above depth"); // R3

  AST_LIVE_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    liveCnt <= count) else $error("live count above stored count"); // R8

  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    !((count > 1 && slot[0] == slot[1]) || (count > 2 && (slot[0] == slot[2] || slot[1] == slot[2]))
      || (count > 3 && (slot[0] == slot[3] || slot[1] == slot[3] || slot[2] == slot[3]))))
    else $error("requester queued twice"); // R3
endmodule

// File: rtl/fcfs_arb_ctrl.sv
module fcfs_arb_ctrl
  import fcfs_pkg::*;
#(
  parameter logic [3:0] LFSR_SEED = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ARB_N-1:0] reqActive,
  input  logic             en_n,
  input  reqId_t           headId,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] liveCnt,
  output qStrobe_t         strb,
  output logic [ARB_N-1:0] gntOut_n
);
  logic [ARB_N-1:0] prevActive;
  logic [ARB_N-1:0] arrive;
  logic [ARB_N-1:0] withdraw;
  logic             multi;
  logic [3:0]       lfsr;
  logic             tieHold;
  reqId_t           winner;
  reqId_t           probe;
  logic             found;
  logic             gntOn;

  assign arrive   = reqActive & ~prevActive;
  assign withdraw = ~reqActive & prevActive;
  assign multi    = $countones(arrive) > 1;

  always_comb begin
    winner = '0;
    found  = 1'b0;
    probe  = '0;
    for (int k = 0; k < ARB_N; k++) begin
      probe = lfsr[ID_W-1:0] + ID_W'(k);
      if (!found && arrive[probe]) begin
        winner = probe;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    strb.dropMask   = withdraw;
    strb.addMask    = arrive;
    strb.firstValid = multi;
    strb.firstId    = winner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevActive <= '0;
      lfsr       <= LFSR_SEED;
      tieHold    <= 1'b0;
    end else begin
      prevActive <= reqActive;
      lfsr       <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      tieHold    <= multi && (liveCnt == '0);
    end
  end

  assign gntOn = !en_n && (count != '0) && !tieHold;

  for (genvar g = 0; g < ARB_N; g++) begin : g_gnt
    assign gntOut_n[g] = ~(gntOn && headId == ID_W'(g));
  end

  AST_TIE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    tieHold |-> (($past(arrive) >> headId) & 1) != 0)
    else $error("tie winner was not among the arrivals"); // R5

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 4'b0000) else $error("tie-break register stuck at zero"); // R5
endmodule

// File: rtl/fcfs_bus_arbiter.sv
module fcfs_bus_arbiter
  import fcfs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] LFSR_SEED   = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ARB_N-1:0] req_n,
  input  logic             en_n,
  output logic [ARB_N-1:0] gnt_n
);
  logic [ARB_N-1:0] reqActive;
  qStrobe_t         strb;
  reqId_t           headId;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] liveCnt;

  fcfs_req_sync #(.WIDTH(ARB_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .reqRaw_n(req_n), .reqActive(reqActive));

  fcfs_arb_ctrl #(.LFSR_SEED(LFSR_SEED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqActive(reqActive), .en_n(en_n),
    .headId(headId), .count(count), .liveCnt(liveCnt),
    .strb(strb), .gntOut_n(gnt_n));

  fcfs_queue_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .headId(headId), .count(count), .liveCnt(liveCnt));

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n)) else $error("two grants active"); // R4

  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (gnt_n == '1)) else $error("grant while enable high"); // R7

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1) |-> ((~gnt_n & $past(reqActive)) != '0))
    else $error("grant to a line that was not requesting"); // R9
endmodule

// File: tb/fcfs_bus_arbiter_tb.sv
module fcfs_bus_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       en_n = 1'b0;
  logic [3:0] gnt_n;

  int checks = 0;
  int errors = 0;
  int monViol = 0;
  bit monOn = 1'b0;

  fcfs_bus_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req_n(req_n), .en_n(en_n), .gnt_n(gnt_n));

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  function automatic logic [3:0] expPins(input int id);
    return (id < 0) ? 4'hF : ~(4'b0001 << id);
  endfunction

  task automatic chk(input string tag, input int id);
    checks++;
    if (gnt_n !== expPins(id)) begin
      errors++;
      $display("FAIL %s gnt_n=%b expected=%b", tag, gnt_n, expPins(id));
    end
  endtask

  function automatic int gntId();
    for (int i = 0; i < 4; i++) if (gnt_n == ~(4'b0001 << i)) return i;
    return -1;
  endfunction

  // every cycle: one-hot-or-none, and nothing while enable high
  always @(negedge clk) begin
    if (monOn) begin
      if (!$onehot0(~gnt_n)) begin
        monViol++;
        $display("FAIL R4 gnt_n=%b expected one-hot or none", gnt_n);
      end
      if (en_n && gnt_n != 4'hF) begin
        monViol++;
        $display("FAIL R7 gnt_n=%b expected=1111 with enable high", gnt_n);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int perm[4];
    int q[$];
    int w;
    // R1: reset state
    #12; chk("R1 in reset", -1);
    @(posedge clk); #1 rst_n = 1'b1;
    monOn = 1'b1;
    step(6); chk("R1 idle after reset", -1);

    // R2: lone request per line, exact latency
    for (int i = 0; i < 4; i++) begin
      req_n[i] = 1'b0;
      step(2); chk("R2 not yet granted", -1);
      step(1); chk("R2 granted own line", i);
      req_n[i] = 1'b1;
      step(3); chk("R2 released", -1);
    end

    // R3/R4: every arrival permutation, one cycle apart
    for (int p = 0; p < 24; p++) begin
      int rem[$];
      int r;
      rem = '{0, 1, 2, 3};
      r = p;
      for (int k = 0; k < 4; k++) begin
        int f;
        f = 1;
        for (int m = 1; m < 4 - k; m++) f *= m;
        perm[k] = rem[r / f];
        rem.delete(r / f);
        r = r % f;
      end
      for (int k = 0; k < 4; k++) begin
        req_n[perm[k]] = 1'b0;
        step(1);
      end
      step(3); chk("R3 first arrival granted", perm[0]);
      for (int k = 0; k < 4; k++) begin
        req_n[perm[k]] = 1'b1;
        step(2); chk("R4 old grant held to hand-over edge", perm[k]);
        step(1); chk("R3 next in arrival order", (k < 3) ? perm[k + 1] : -1);
      end
      step(2);
    end

    // R5/R6: every tied subset on an idle bus, twice each
    for (int rep = 0; rep < 2; rep++) begin
      for (int s = 3; s < 16; s++) begin
        if ($countones(s[3:0]) < 2) continue;
        req_n = ~s[3:0];
        step(3); chk("R5 all grants held off during tie-break", -1);
        step(1);
        w = gntId();
        checks++;
        if (w < 0 || !s[w]) begin
          errors++;
          $display("FAIL R5 gnt_n=%b expected one grant within set %b", gnt_n, s[3:0]);
          w = -1;
        end
        if (w >= 0) begin
          q.delete();
          for (int i = 0; i < 4; i++) if (s[i] && i != w) q.push_back(i);
          req_n[w] = 1'b1;
          foreach (q[k]) begin
            step(3); chk("R6 losers in ascending index", q[k]);
            req_n[q[k]] = 1'b1;
          end
          step(3); chk("R6 queue drained", -1);
        end
        req_n = 4'hF;
        step(3);
      end
    end

    // R6: tie behind a busy holder, no hold-off for the holder
    req_n[0] = 1'b0; step(3); chk("R6 holder granted", 0);
    req_n[3:1] = 3'b000;
    step(4); chk("R6 holder kept during tie", 0);
    req_n[0] = 1'b1;
    step(3);
    w = gntId();
    checks++;
    if (w < 1) begin
      errors++;
      $display("FAIL R6 gnt_n=%b expected a grant among lines 1..3", gnt_n);
    end else begin
      q.delete();
      for (int i = 1; i < 4; i++) if (i != w) q.push_back(i);
      req_n[w] = 1'b1;
      foreach (q[k]) begin
        step(3); chk("R6 losers after busy tie", q[k]);
        req_n[q[k]] = 1'b1;
      end
    end
    req_n = 4'hF; step(4); chk("R6 drained", -1);

    // R7: enable gating, queue unaffected
    req_n[2] = 1'b0; step(1); req_n[0] = 1'b0; step(3);
    chk("R7 grant with enable low", 2);
    #1 en_n = 1'b1; #1; chk("R7 enable high forces off", -1);
    req_n[2] = 1'b1; step(1); req_n[3] = 1'b0; step(4);
    chk("R7 off while queue moves", -1);
    en_n = 1'b0; #1; chk("R7 queue kept under enable", 0);
    req_n[0] = 1'b1; step(3); chk("R7 arrival under enable queued", 3);
    req_n[3] = 1'b1; step(3); chk("R7 drained", -1);

    // R8: withdraw waiting requesters
    req_n[1] = 1'b0; step(1); req_n[3] = 1'b0; step(1);
    req_n[0] = 1'b0; step(1); req_n[2] = 1'b0; step(3);
    chk("R8 holder granted", 1);
    req_n[0] = 1'b1; step(4); chk("R8 grant unchanged after withdraw", 1);
    req_n[1] = 1'b1; step(3); chk("R8 order kept after withdraw", 3);
    req_n[3] = 1'b1; step(3); chk("R8 last waiting", 2);
    req_n[2] = 1'b1; step(3); chk("R8 drained", -1);
    req_n[2] = 1'b0; step(1); req_n[0] = 1'b0; step(1);
    req_n[3] = 1'b0; step(1); req_n[1] = 1'b0; step(3);
    req_n[0] = 1'b1; req_n[3] = 1'b1; step(4);
    chk("R8 double withdraw keeps grant", 2);
    req_n[2] = 1'b1; step(3); chk("R8 survivor next", 1);
    req_n[1] = 1'b1; step(3);

    // R9: line 3 held high throughout
    req_n[2:0] = 3'b000; step(4);
    for (int k = 0; k < 3; k++) begin
      w = gntId();
      checks++;
      if (w < 0 || w == 3) begin
        errors++;
        $display("FAIL R9 gnt_n=%b expected grant among lines 0..2", gnt_n);
        break;
      end
      req_n[w] = 1'b1;
      step(3);
    end
    chk("R9 unused line never granted", -1);

    step(4);
    checks++;
    if (monViol != 0) begin
      errors++;
      $display("FAIL R4 monitor violations=%0d expected=0", monViol);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule